// File: doc/BRIEF.md
# Event Flag Wait/Clear Table

This block keeps one sticky bit per hardware event. Pulses from the display pipeline and other sources set these bits. Typical sources are frame-start strobes, frame-end strobes, stream-end strobes and underrun strobes. A command sequencer sends one request at a time. Each request names an event and carries a 32-bit option word.

The option word can ask the request to stall until the flag reaches a given level. It can also ask for a new flag value to be written once the request is granted. The most common use is wait-then-clear. A thread stalls until the strobe it depends on has fired, then consumes that strobe in the same step. A request without the wait bit simply writes the flag, which is how a thread discards a stale event before it starts waiting.

The current flag vector is brought out as an output so that the surrounding logic can observe it.

Top module: `evt_flag_table`

## Requirements
- R1: After reset every flag reads 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A 1 on `evt_set[i]` at a clock edge makes `flags[i]` read 1 from the next cycle on. Several pulses before a clear merge into one flag, so a single clear request returns it to 0.
- R3: A request accepted with `req_idx` of NUM_EVENTS (260 by default) or above gets `rsp_valid` with `rsp_err` = 1 in the cycle after acceptance, and no flag changes.
- R4: Option word fields are as follows.
  - Wait value: bits 11:0.
  - Wait enable: bit 15.
  - Update value: bits 27:16.
  - Update enable: bit 31.
- R5: With wait enable set and a nonzero wait value, the request stalls while the flag is 0. `rsp_valid` rises one cycle after the first cycle in which the flag reads 1.
- R6: With wait enable set and a wait value of 0, the request stalls while the flag is 1.
- R7: With wait enable clear, `rsp_valid` (with `rsp_err` = 0) is asserted in the second cycle after the acceptance cycle.
- R8: At the grant, if update enable is set, the flag becomes 1 for a nonzero update value and 0 for a zero update value. If update enable is clear, the flag is left as it was.
- R9: A set pulse on an event in the same cycle that a grant writes 0 to that event leaves the flag at 1.
- R10: `req_ready` is 0 from the cycle after a valid-index acceptance until the grant cycle, so at most one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | NUM_EVENTS | One-cycle set strobes, one per event |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_idx | input | IDX_W | Event index of the request |
| req_opt | input | 32 | Option word (wait/update fields) |
| rsp_valid | output | 1 | One-cycle grant or error response |
| rsp_err | output | 1 | Response is an index error |
| flags | output | NUM_EVENTS | Current flag vector |

## Verification
The hardest case to reach is the collision of a hardware strobe with the clearing write. The strobe must land in exactly the cycle in which the grant is decided. Waiting for an external sign would be too late.

The stimulus therefore issues a no-wait clear on an idle event. Such a request is always decided in the cycle after acceptance, so the bench raises the strobe in that cycle. For the long stall, a wait-for-one request is left pending for several cycles. The strobe is then injected, and the flag is seen rising one cycle before the grant clears it.

A wait-for-zero on a set flag can never complete. It is left pending and then cut off by reset.

// File: rtl/evt_flag_table.sv
module evt_flag_table #(
  parameter int NUM_EVENTS = 260,
  parameter int IDX_W      = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVENTS-1:0] evt_set,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [IDX_W-1:0]      req_idx,
  input  logic [31:0]           req_opt,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [NUM_EVENTS-1:0] flags
);
  localparam int VAL_W   = 12;
  localparam int WEN_BIT = 15;
  localparam int UVAL_LO = 16;
  localparam int UEN_BIT = 31;

  logic [NUM_EVENTS-1:0] flags_q, flags_d;
  logic                  busy_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  wait_en_q, upd_en_q;
  logic [VAL_W-1:0]      wait_val_q, upd_val_q;
  logic                  rsp_valid_q, rsp_err_q;

  logic accept, bad_idx, cur, wait_ok, fire;

  assign accept  = req_valid && !busy_q;
  assign bad_idx = (32'(req_idx) >= NUM_EVENTS);
  assign cur     = flags_q[idx_q];
  assign wait_ok = !wait_en_q || (cur == (wait_val_q != '0));
  assign fire    = busy_q && wait_ok;

  always_comb begin
    flags_d = flags_q;
    if (fire && upd_en_q)
      flags_d[idx_q] = (upd_val_q != '0);
    flags_d = flags_d | evt_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q     <= '0;
      busy_q      <= 1'b0;
      idx_q       <= '0;
      wait_en_q   <= 1'b0;
      upd_en_q    <= 1'b0;
      wait_val_q  <= '0;
      upd_val_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      flags_q     <= flags_d;
      rsp_valid_q <= fire || (accept && bad_idx);
      rsp_err_q   <= accept && bad_idx;
      if (accept && !bad_idx) begin
        busy_q     <= 1'b1;
        idx_q      <= req_idx;
        wait_val_q <= req_opt[VAL_W-1:0];
        wait_en_q  <= req_opt[WEN_BIT];
        upd_val_q  <= req_opt[UVAL_LO +: VAL_W];
        upd_en_q   <= req_opt[UEN_BIT];
      end else if (fire) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign req_ready = !busy_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign flags     = flags_q;
endmodule

// File: rtl/evt_flag_table_chk.sv
module evt_flag_table_chk #(
  parameter int NUM_EVENTS = 260,
  parameter int IDX_W      = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_EVENTS-1:0] evt_set,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [IDX_W-1:0]      req_idx,
  input logic                  rsp_valid,
  input logic                  rsp_err,
  input logic [NUM_EVENTS-1:0] flags,
  input logic                  busy_q,
  input logic [IDX_W-1:0]      idx_q,
  input logic                  upd_en_q,
  input logic [11:0]           upd_val_q
);
  logic pv;
  always_ff @(posedge clk) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  AST_BAD_IDX_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && 32'(req_idx) >= NUM_EVENTS) |=> (rsp_valid && rsp_err)); // R3

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n || !pv)
    ((flags & $past(evt_set)) == $past(evt_set))); // R2

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !req_ready); // R10

  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || !pv)
    rsp_valid |-> $past(busy_q || (req_valid && req_ready))); // R7

  AST_CLEAR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n || !pv)
    (rsp_valid && !rsp_err && upd_en_q && upd_val_q == 12'd0 && !$past(evt_set[idx_q]))
      |-> !flags[idx_q]); // R8

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !pv |-> (req_ready && !rsp_valid)); // R1
endmodule

bind evt_flag_table evt_flag_table_chk #(.NUM_EVENTS(NUM_EVENTS), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .req_valid(req_valid),
  .req_ready(req_ready), .req_idx(req_idx), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .flags(flags), .busy_q(busy_q), .idx_q(idx_q),
  .upd_en_q(upd_en_q), .upd_val_q(upd_val_q)
);

// File: tb/evt_flag_table_tb_top.sv
module evt_flag_table_tb_top;
  localparam int N  = 260;
  localparam int IW = 9;
  localparam int NV = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] evt_set = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [IW-1:0] req_idx = '0;
  logic [31:0] req_opt = '0;
  logic rsp_valid, rsp_err;
  logic [N-1:0] flags;
  logic [N-1:0] model = '0;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  evt_flag_table #(.NUM_EVENTS(N), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .req_valid(req_valid),
    .req_ready(req_ready), .req_idx(req_idx), .req_opt(req_opt),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .flags(flags)
  );

  // {idx, option, pre-set, expect err, expect flag after}
  localparam logic [43:0] VEC [NV] = '{
    {9'd11,  32'h8000_8001, 1'b1, 1'b0, 1'b0},
    {9'd39,  32'h8000_0000, 1'b1, 1'b0, 1'b0},
    {9'd53,  32'h8001_0000, 1'b0, 1'b0, 1'b1},
    {9'd63,  32'h0000_8001, 1'b1, 1'b0, 1'b1},
    {9'd260, 32'h8000_8001, 1'b0, 1'b1, 1'b0},
    {9'd511, 32'h8000_0000, 1'b0, 1'b1, 1'b0},
    {9'd0,   32'h0000_0000, 1'b0, 1'b0, 1'b0},
    {9'd259, 32'h8000_8000, 1'b0, 1'b0, 1'b0},
    {9'd17,  32'h8000_8005, 1'b1, 1'b0, 1'b0}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int i);
    evt_set[i] = 1'b1;
    step();
    evt_set = '0;
    model[i] = 1'b1;
  endtask

  task automatic issue(input logic [IW-1:0] i, input logic [31:0] o);
    req_valid = 1'b1; req_idx = i; req_opt = o;
    step();
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    step(); step();
    rst_n = 1'b1;
    step();
    chk(flags == '0, "R1 flags", 64'(flags[63:0]), 0);
    chk(req_ready && !rsp_valid, "R1 ready/rsp", {62'd0, req_ready, rsp_valid}, 2);

    for (int v = 0; v < NV; v++) begin
      logic [IW-1:0] i;
      logic [31:0] o;
      logic pre, eerr, eflg;
      {i, o, pre, eerr, eflg} = VEC[v];
      if (pre) begin
        pulse(int'(i));
        chk(flags[i] == 1'b1, "R2 set pulse", 64'(flags[i]), 1);
      end
      issue(i, o);
      cyc = 1;
      while (!rsp_valid && cyc < 6) begin step(); cyc++; end
      chk(rsp_valid && rsp_err == eerr, "R3/R7 response err", 64'(rsp_err), 64'(eerr));
      chk(cyc == (eerr ? 1 : 2), "R7 latency", 64'(cyc), eerr ? 1 : 2);
      if (!eerr) model[i] = eflg;
      chk(flags == model, "R4/R8 flag vector", 64'(flags[i % N]), 64'(model[i % N]));
      step();
    end

    // R2 merge of repeated pulses
    pulse(12); pulse(12); pulse(12);
    issue(9'd12, 32'h8000_0000);
    step();
    model[12] = 1'b0;
    chk(flags[12] == 1'b0, "R2 merged clear", 64'(flags[12]), 0);

    // R9 set wins against clear
    issue(9'd45, 32'h8000_0000);
    evt_set[45] = 1'b1;
    step();
    evt_set = '0;
    model[45] = 1'b1;
    chk(rsp_valid && flags[45], "R9 set wins", 64'(flags[45]), 1);
    step();

    // R5 / R10 long stall
    issue(9'd40, 32'h8000_8001);
    for (int k = 0; k < 4; k++) begin
      chk(!rsp_valid && !req_ready, "R5/R10 stall", {62'd0, rsp_valid, req_ready}, 0);
      step();
    end
    evt_set[40] = 1'b1;
    step();
    evt_set = '0;
    chk(flags[40] && !rsp_valid, "R5 flag seen before grant", {62'd0, flags[40], rsp_valid}, 2);
    step();
    chk(rsp_valid && !rsp_err && !flags[40] && req_ready, "R5 grant",
        {60'd0, rsp_valid, rsp_err, flags[40], req_ready}, 9);

    // R6 wait-for-zero on a set flag stalls
    pulse(57);
    issue(9'd57, 32'h8000_8000);
    for (int k = 0; k < 4; k++) begin
      chk(!rsp_valid && flags[57], "R6 wait for zero", {62'd0, rsp_valid, flags[57]}, 1);
      step();
    end
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk(flags == '0 && req_ready && !rsp_valid, "R1 reset aborts",
        {61'd0, |flags, req_ready, rsp_valid}, 2);

    summary();
    $finish;
  end
endmodule